// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Controller

This block is the buffering and event core of a memory-mapped serial port. It keeps a receive FIFO filled from a byte-wide input port and a transmit FIFO that software fills through a 32-bit register bus and that a downstream serializer drains through a ready/valid output port. Every cycle it rebuilds live status flags from both FIFO counts and two programmable trigger levels. It folds those flags, an overflow event and a receive-timeout event into a sticky interrupt-status register that software clears by writing 1. One interrupt line is driven through a mask.

A channel-mode field decides where incoming bytes go and which FIFO's free space limits the input port. In normal mode bytes go to the receive FIFO. In echo mode they go to both FIFOs. In remote-loopback mode they go only to the transmit FIFO. In local-loopback mode the port accepts bytes and discards them. Bit timing, framing and parity live outside the block. The receive timeout counts a programmable number of clock cycles per bit.

The register map uses word indices on `reg_addr`: 0 control, 1 mode, 2 mask, 3 interrupt status, 4 RX trigger, 5 TX trigger, 6 status (read-only), 7 data. A write to word 7 pushes into the TX FIFO and a read of word 7 pops from the RX FIFO. Register reads are combinational and side effects take place at the clock edge.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the control register reads 0x00000128, the mask reads 0, the status reads 0x0000000A with both FIFOs empty, and `irq` is low.
- R2: Status bit 0 is set while the RX count is at or above the RX trigger, bit 1 while the RX count is zero, and bit 2 while the RX count equals DEPTH.
- R3: Status bit 3 is set while the TX count is zero, bit 4 while it equals DEPTH, and bit 13 while it is at or above the TX trigger.
- R4: Each cycle, status bits 4:0 are ORed into interrupt-status bits 4:0 and the TX-trigger condition is ORed into interrupt-status bit 10. Writing 1 to an interrupt-status bit clears it, but a condition present in that same cycle sets it again.
- R5: `irq` is high exactly when the mask register ANDed with the interrupt-status register is nonzero.
- R6: An RX byte that arrives while the RX FIFO is full is dropped and sets interrupt-status bit 5. A TX data write while the TX FIFO is full is dropped and sets the same bit.
- R7: Mode register bits 1:0 select the channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback. `rx_ready` requires RX free space in modes 0 and 1, and TX free space in modes 1 and 3. Accepted bytes go to the RX FIFO in modes 0 and 1 and to the TX FIFO in modes 1 and 3.
- R8: A write to the data word is ignored unless control bit 4 (transmit enable) is 1 and control bit 5 (transmit disable) is 0.
- R9: Writing 1 to control bit 0 empties the RX FIFO and writing 1 to control bit 1 empties the TX FIFO. Both bits read back as 0.
- R10: Interrupt-status bit 8 sets 40*BIT_CYCLES cycles after the most recent byte stored in the RX FIFO, unless another byte arrives first.
- R11: Reads of the data word return RX bytes in arrival order. A read while the RX FIFO is empty returns 0 and changes nothing.
- R12: `tx_valid` is high while the TX FIFO holds data. Each cycle with `tx_valid` and `tx_ready` both high removes one byte, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX on data word) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Input port can take a byte in the current mode |
| tx_valid | output | 1 | TX FIFO holds a byte |
| tx_data | output | 8 | Oldest TX byte |
| tx_ready | input | 1 | Downstream takes the byte |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that the bus never raises `reg_we` and `reg_re` together. They also assume that echo-mode input never coincides with a data-word write, because those two pushes compete for the TX FIFO. The overflow checks rely on a source that may still present a byte while `rx_ready` is low, so the stimulus deliberately pushes into full FIFOs. Otherwise it drives one transaction at a time on the falling edge. The stimulus uses a four-entry configuration, so every RX and TX occupancy is swept against every trigger value, and every channel mode is tried with each FIFO full in turn.

// File: rtl/ufi_pkg.sv
package ufi_pkg;
  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_ECHO   = 2'd1,
    CM_LOCAL  = 2'd2,
    CM_REMOTE = 2'd3
  } chan_mode_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_MODE   = 3'd1;
  localparam logic [2:0] A_MASK   = 3'd2;
  localparam logic [2:0] A_ISR    = 3'd3;
  localparam logic [2:0] A_RXTRIG = 3'd4;
  localparam logic [2:0] A_TXTRIG = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;
  localparam logic [2:0] A_DATA   = 3'd7;

  localparam int ST_RXTRIG  = 0;
  localparam int ST_RXEMPTY = 1;
  localparam int ST_RXFULL  = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_TXFULL  = 4;
  localparam int ST_TXTRIG  = 13;

  localparam int ISR_W     = 11;
  localparam int IS_OVF    = 5;
  localparam int IS_TMO    = 8;
  localparam int IS_TXTRIG = 10;

  localparam int CT_RXRST = 0;
  localparam int CT_TXRST = 1;
  localparam int CT_TXEN  = 4;
  localparam int CT_TXDIS = 5;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0128;
endpackage

// File: rtl/ufi_fifo.sv
module ufi_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign rdata   = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = wr_q + AW'(1);
      if (do_pop)  rd_n = rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + CW'(1);
        2'b01:   cnt_n = cnt_q - CW'(1);
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  AST_FIFO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> (cnt_q == $past(cnt_q) + CW'(1))); // R11
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == CW'(DEPTH))); // R6
endmodule

// File: rtl/ufi_timeout.sv
module ufi_timeout #(
  parameter int TMO = 640,
  localparam int TW = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic kick,
  output logic fire
);
  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                cnt_n = '0;
    else if (kick)          cnt_n = TW'(TMO);
    else if (cnt_q != '0)   cnt_n = cnt_q - TW'(1);
  end

  assign fire = (cnt_q == TW'(1)) && !kick && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_TMO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !clr) |=> !fire); // R10
endmodule

// File: rtl/ufi_irq.sv
module ufi_irq
  import ufi_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_trig,
  input  logic [CW-1:0]    tx_trig,
  input  logic             ovf_evt,
  input  logic             tmo_evt,
  input  logic             w1c_we,
  input  logic [ISR_W-1:0] w1c_bits,
  input  logic [ISR_W-1:0] mask,
  output logic [31:0]      status,
  output logic [ISR_W-1:0] isr,
  output logic             irq
);
  logic [ISR_W-1:0] isr_q, isr_n, set_vec, clr_vec;
  logic             tx_trig_hit;

  assign tx_trig_hit = (tx_cnt >= tx_trig);

  always_comb begin
    status             = '0;
    status[ST_RXTRIG]  = (rx_cnt >= rx_trig);
    status[ST_RXEMPTY] = (rx_cnt == '0);
    status[ST_RXFULL]  = (rx_cnt == CW'(DEPTH));
    status[ST_TXEMPTY] = (tx_cnt == '0);
    status[ST_TXFULL]  = (tx_cnt == CW'(DEPTH));
    status[ST_TXTRIG]  = tx_trig_hit;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[4:0]       = status[4:0];
    set_vec[IS_OVF]    = ovf_evt;
    set_vec[IS_TMO]    = tmo_evt;
    set_vec[IS_TXTRIG] = tx_trig_hit;
    clr_vec            = w1c_we ? w1c_bits : '0;
    isr_n              = (isr_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_n;
  end

  assign isr = isr_q;
  assign irq = |(isr_q & mask);

  AST_TXTRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt >= tx_trig) |=> isr_q[IS_TXTRIG]); // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q[IS_OVF] && !(w1c_we && w1c_bits[IS_OVF])) |=> isr_q[IS_OVF]); // R4
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import ufi_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int BIT_CYCLES = 16,
  localparam int CW        = $clog2(DEPTH) + 1,
  localparam int TMO       = 40 * BIT_CYCLES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        irq
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [31:0]      ctrl_q, ctrl_n;
  chan_mode_e       mode_q, mode_n;
  logic [ISR_W-1:0] mask_q, mask_n;
  logic [CW-1:0]    rxtrig_q, rxtrig_n, txtrig_q, txtrig_n;

  logic wr_ctrl, wr_data, rd_data;
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign rd_data = reg_re && (reg_addr == A_DATA);

  logic rx_clr, tx_clr, tx_enabled;
  assign rx_clr     = wr_ctrl && reg_wdata[CT_RXRST];
  assign tx_clr     = wr_ctrl && reg_wdata[CT_TXRST];
  assign tx_enabled = ctrl_q[CT_TXEN] && !ctrl_q[CT_TXDIS];

  always_comb begin
    ctrl_n   = ctrl_q;
    mode_n   = mode_q;
    mask_n   = mask_q;
    rxtrig_n = rxtrig_q;
    txtrig_n = txtrig_q;
    if (reg_we) begin
      case (reg_addr)
        A_CTRL:   ctrl_n   = reg_wdata & ~(32'(1) << CT_RXRST | 32'(1) << CT_TXRST);
        A_MODE:   mode_n   = chan_mode_e'(reg_wdata[1:0]);
        A_MASK:   mask_n   = reg_wdata[ISR_W-1:0];
        A_RXTRIG: rxtrig_n = reg_wdata[CW-1:0];
        A_TXTRIG: txtrig_n = reg_wdata[CW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q   <= CTRL_RESET;
      mode_q   <= CM_NORMAL;
      mask_q   <= '0;
      rxtrig_q <= CW'(DEPTH / 2);
      txtrig_q <= CW'(DEPTH / 2);
    end else begin
      ctrl_q   <= ctrl_n;
      mode_q   <= mode_n;
      mask_q   <= mask_n;
      rxtrig_q <= rxtrig_n;
      txtrig_q <= txtrig_n;
    end
  end

  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic [7:0]    rx_head;
  logic          to_rx, to_tx, rx_push, tx_push_req, reg_tx_push, tx_pop;
  logic [7:0]    tx_push_data;
  logic          ovf_evt, tmo_evt;

  assign to_rx = rx_valid && (mode_q == CM_NORMAL || mode_q == CM_ECHO);
  assign to_tx = rx_valid && (mode_q == CM_REMOTE || mode_q == CM_ECHO);

  always_comb begin
    case (mode_q)
      CM_NORMAL: rx_ready = !rx_full;
      CM_ECHO:   rx_ready = !rx_full && !tx_full;
      CM_REMOTE: rx_ready = !tx_full;
      default:   rx_ready = 1'b1;
    endcase
  end

  assign rx_push      = to_rx && !rx_full;
  assign reg_tx_push  = wr_data && tx_enabled;
  assign tx_push_req  = to_tx || reg_tx_push;
  assign tx_push_data = to_tx ? rx_data : reg_wdata[7:0];
  assign tx_pop       = tx_valid && tx_ready;
  assign ovf_evt      = (to_rx && rx_full) || (tx_push_req && tx_full) ||
                        (to_tx && reg_tx_push);

  ufi_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .clr(rx_clr), .push(rx_push),
    .wdata(rx_data), .pop(rd_data), .rdata(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  ufi_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .clr(tx_clr), .push(tx_push_req),
    .wdata(tx_push_data), .pop(tx_pop), .rdata(tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );

  assign tx_valid = !tx_empty;

  ufi_timeout #(.TMO(TMO)) u_tmo (
    .clk(clk), .rst_n(rst_sync_n), .clr(rx_clr),
    .kick(rx_push), .fire(tmo_evt)
  );

  logic [31:0]      status;
  logic [ISR_W-1:0] isr;

  ufi_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_trig(rxtrig_q), .tx_trig(txtrig_q), .ovf_evt(ovf_evt),
    .tmo_evt(tmo_evt), .w1c_we(reg_we && (reg_addr == A_ISR)),
    .w1c_bits(reg_wdata[ISR_W-1:0]), .mask(mask_q), .status(status),
    .isr(isr), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = ctrl_q;
      A_MODE:   reg_rdata = {30'd0, mode_q};
      A_MASK:   reg_rdata = 32'(mask_q);
      A_ISR:    reg_rdata = 32'(isr);
      A_RXTRIG: reg_rdata = 32'(rxtrig_q);
      A_TXTRIG: reg_rdata = 32'(txtrig_q);
      A_STATUS: reg_rdata = status;
      default:  reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
    endcase
  end

  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_data && !tx_enabled && !to_tx && !tx_pop && !tx_clr)
      |=> (tx_cnt == $past(tx_cnt))); // R8
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_full && mode_q == CM_NORMAL) |=> isr[IS_OVF]); // R6
  AST_SWRST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_clr |=> (rx_cnt == '0 && !ctrl_q[CT_RXRST])); // R9
  AST_ECHO_BOTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && rx_ready && mode_q == CM_ECHO && !rd_data && !tx_pop && !wr_ctrl && !wr_data)
      |=> (rx_cnt == $past(rx_cnt) + CW'(1) && tx_cnt == $past(tx_cnt) + CW'(1))); // R7
endmodule

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int BC = 2;

  logic        clk, rst_n, we, re, rxv, rxr, txv, txr, irq;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  rxd, txd;
  int nchk, nerr;
  logic [31:0] v;

  uart_fifo_irq #(.DEPTH(D), .BIT_CYCLES(BC)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .rx_valid(rxv), .rx_data(rxd),
    .rx_ready(rxr), .tx_valid(txv), .tx_data(txd), .tx_ready(txr), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    @(negedge clk); rxv = 1'b1; rxd = d;
    @(negedge clk); rxv = 1'b0;
  endtask

  function automatic logic [31:0] exp_st(int rn, int tn, int rt, int tt);
    logic [31:0] s = '0;
    s[0]  = (rn >= rt);
    s[1]  = (rn == 0);
    s[2]  = (rn == D);
    s[3]  = (tn == 0);
    s[4]  = (tn == D);
    s[13] = (tn >= tt);
    return s;
  endfunction

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; we = 0; re = 0; addr = 0; wdata = 0; rxv = 0; rxd = 0; txr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h128);
    rd(3'd2, v); chk("R1 mask", v, 0);
    rd(3'd6, v); chk("R1 status", v, 32'h0A);
    chk("R1 irq", irq, 0);
    rd(3'd3, v); chk("R4 isr after reset", v, 32'h0A);

    // R2 sweep RX occupancy against every RX trigger
    for (int rt = 0; rt <= D; rt++) begin
      wr(3'd4, rt);
      wr(3'd0, 32'h129);
      for (int n = 0; n <= D; n++) begin
        rd(3'd6, v); chk("R2 rx status", v, exp_st(n, 0, rt, D / 2));
        if (n < D) rxpush(8'(n + 16 * rt));
      end
    end

    // R6 RX overflow
    wr(3'd3, 32'h20);
    rd(3'd3, v); chk("R6 ovf clear", v & 32'h20, 0);
    rxpush(8'hEE);
    rd(3'd6, v); chk("R6 rx still full", v, exp_st(D, 0, D, D / 2));
    rd(3'd3, v); chk("R6 rx ovf set", v & 32'h20, 32'h20);

    // R4 write-1-clear, persisting conditions win
    wr(3'd3, 32'h7FF);
    rd(3'd3, v); chk("R4 w1c resets live", v, 32'h0D);

    // R11 read order and empty read
    for (int k = 0; k < D; k++) begin
      rd(3'd7, v); chk("R11 rx order", v, 32'(k + 16 * D));
    end
    rd(3'd7, v); chk("R11 empty read", v, 0);
    rd(3'd6, v); chk("R11 empty unchanged", v, exp_st(0, 0, D, D / 2));

    // R5 interrupt mask
    wr(3'd2, 32'h002); @(negedge clk); chk("R5 irq on", irq, 1);
    wr(3'd3, 32'h400);
    wr(3'd2, 32'h400); @(negedge clk); chk("R5 irq off", irq, 0);
    wr(3'd2, 32'h000);

    // R8 tx gated while disabled (reset control)
    wr(3'd7, 32'h55);
    rd(3'd6, v); chk("R8 tx ignored", v, exp_st(0, 0, D, D / 2));
    chk("R8 tx_valid low", txv, 0);
    wr(3'd0, 32'h030);
    wr(3'd7, 32'h56);
    rd(3'd6, v); chk("R8 tx disable wins", v, exp_st(0, 0, D, D / 2));

    // R3 sweep TX occupancy against every TX trigger
    for (int tt = 0; tt <= D; tt++) begin
      wr(3'd5, tt);
      wr(3'd0, 32'h012);
      wr(3'd3, 32'h400);
      for (int n = 0; n <= D; n++) begin
        rd(3'd6, v); chk("R3 tx status", v, exp_st(0, n, D, tt));
        if (tt > 0 && n == tt - 1) begin
          rd(3'd3, v); chk("R4 isr10 below trig", v & 32'h400, 0);
        end
        if (n < D) wr(3'd7, 32'(n));
      end
      rd(3'd3, v); chk("R4 isr10 set", v & 32'h400, 32'h400);
    end

    // R6 TX truncation
    wr(3'd3, 32'h20);
    wr(3'd7, 32'h99);
    rd(3'd3, v); chk("R6 tx ovf set", v & 32'h20, 32'h20);
    rd(3'd6, v); chk("R6 tx still full", v, exp_st(0, D, D, D));

    // R12 drain through the handshake
    for (int k = 0; k < D; k++) begin
      @(negedge clk);
      chk("R12 tx_valid", txv, 1);
      chk("R12 tx order", txd, 32'(k));
      txr = 1'b1;
      @(negedge clk); txr = 1'b0;
    end
    chk("R12 drained", txv, 0);

    // R9 self-clearing soft resets
    wr(3'd0, 32'h013);
    rd(3'd0, v); chk("R9 ctrl readback", v, 32'h010);

    // R7 channel modes: routing of one byte
    for (int m = 0; m < 4; m++) begin
      wr(3'd1, m);
      wr(3'd0, 32'h013);
      @(negedge clk); chk("R7 ready when empty", rxr, 1);
      rxpush(8'hA0);
      rd(3'd6, v);
      chk("R7 routing", v, exp_st((m == 0 || m == 1) ? 1 : 0,
                                  (m == 1 || m == 3) ? 1 : 0, D, D));
    end
    // R7 readiness with one FIFO full
    for (int m = 0; m < 4; m++) begin
      wr(3'd1, 0);
      wr(3'd0, 32'h013);
      for (int k = 0; k < D; k++) rxpush(8'(k));
      wr(3'd1, m);
      @(negedge clk); chk("R7 ready rx full", rxr, (m == 2 || m == 3));
      wr(3'd0, 32'h013);
      for (int k = 0; k < D; k++) wr(3'd7, 32'(k));
      @(negedge clk); chk("R7 ready tx full", rxr, (m == 0 || m == 2));
    end

    // R10 receive timeout
    wr(3'd1, 0);
    wr(3'd0, 32'h013);
    wr(3'd3, 32'h100);
    rxpush(8'h11);
    repeat (40) @(negedge clk);
    rd(3'd3, v); chk("R10 no early timeout", v & 32'h100, 0);
    repeat (60) @(negedge clk);
    rd(3'd3, v); chk("R10 timeout set", v & 32'h100, 32'h100);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule